// File: doc/BRIEF.md
# Write-Evict Data Cache Controller

This block is the control path of a set-associative data cache that sits between a load/store unit and an outbound memory request queue. Each cycle it takes at most one request: a load, a global store, a local store or a writeback-class store. In the same cycle it answers with a result code and two event flags. One flag says a read went out to memory and the other says a write went out. Global stores are written through, and a line they hit is evicted. Local and writeback-class stores that hit are kept in the cache and dirty the line. A load miss claims a victim way and requests the whole line. If that victim is dirty, a writeback of the victim is queued behind the read.

The tags, the valid, pending and modified bits, and the per-set LRU ages are all held inside the block. Line data lives in a plain register array. Returning lines arrive on a fill port. A fill completes the pending way, and one cycle later the fill address appears on a ready output. Outbound requests wait in an internal FIFO until the memory side takes them.

Top module: `wecache_top`

## Requirements
- R1: The request kind is encoded as 0 load, 1 global store, 2 local store, 3 writeback store. The result is encoded as 0 hit, 1 miss, 2 refused, 3 idle, and it reads 3 whenever no request is valid. A load that hits returns hit and refreshes LRU. On the next cycle it raises the data-valid output with the 32-bit word at address bits [6:2] of the line.
- R2: A load that misses returns miss and raises the read flag. It queues a read-line entry (queue kind 0) whose address is the block-aligned address (low 7 bits zero) and whose size is the line size, 128. The chosen victim way takes the new tag and becomes pending: not valid and not modified.
- R3: The victim is the lowest-numbered way that is neither valid nor pending. If no such way exists, it is the non-pending way with the oldest LRU age. A hit or an allocation makes its way the youngest. If the victim was valid and modified, a victim-writeback entry (queue kind 2) is queued directly behind the read entry, with the victim's block address and size 128.
- R4: A global store that hits a valid line returns hit and raises the write flag. It invalidates the line and queues the request unchanged, as a write entry (queue kind 1) with the original address and size. LRU is left alone.
- R5: A store of any kind that misses returns miss and raises the write flag. It queues the request unchanged as a write entry and allocates nothing.
- R6: A local or writeback-class store that hits returns hit and refreshes LRU. It marks the line modified and writes its 32-bit data into the addressed word. It queues nothing and raises no flag.
- R7: A request is refused (result 2) in any of these cases: its block is pending in the cache; it is a store that would queue while the queue holds 4 entries; or it is a load miss while occupancy plus one reaches 4 or every way of the set is pending. Occupancy is taken before any pop in the same cycle.
- R8: A refused request raises neither event flag and changes no cache, LRU or queue state.
- R9: A fill whose tag and set match a pending way makes that way valid and clean, writes the whole line, and raises the ready output with the fill address on the next cycle. A fill that matches no pending way is ignored.
- R10: The queue is first in, first out, with at most 4 entries. The head is visible while it is non-empty, and the head is removed on a cycle where both the valid and ready signals of the queue output are high.
- R11: A global store that hits a modified line is illegal and is flagged by an assertion.
- R12: After reset, all lines are invalid, the queue is empty, and way w of every set has LRU age w, so way 3 is the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | Request kind (R1 encoding) |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 8 | Request size in bytes |
| req_wdata | input | 32 | Store data word |
| rsp_status | output | 2 | Result of this cycle's request |
| rsp_read_sent | output | 1 | A line read was queued |
| rsp_write_sent | output | 1 | A write was queued |
| rsp_data_valid | output | 1 | Load-hit data is valid |
| rsp_data | output | 32 | Load-hit data word |
| fill_valid | input | 1 | A returning line is presented |
| fill_addr | input | 32 | Address of the returning line |
| fill_data | input | 1024 | Line contents, word i in bits [32i+31:32i] |
| rdy_valid | output | 1 | A fill completed a waiting miss |
| rdy_addr | output | 32 | Fill address of the completed miss |
| mq_valid | output | 1 | Queue head is valid |
| mq_ready | input | 1 | Memory side takes the head |
| mq_addr | output | 32 | Head address |
| mq_kind | output | 2 | Head kind: 0 read line, 1 write, 2 victim writeback |
| mq_size | output | 8 | Head size in bytes |

## Verification
Two pairs of actions can fall in the same cycle. A fill can arrive while a request is being judged, and the memory side can pop the queue head while a request decides whether to push one or two entries. The bench drives the fill valid signal and the queue ready signal at random under a fixed seed, alongside the requests. A directed case also lands a fill and a load miss to another tag of the same set in one cycle. A reference model judges each request against the state and the queue occupancy from before the clock edge. It then applies the pop, the pushes and the fill together. Results, flags, the queue head, load data and the ready output are compared in every cycle.

// File: rtl/wecache_pkg.sv
// Package: shared encodings and the queue entry layout for the write-evict cache.
// Assumes a 32-bit byte address and request sizes of at most 255 bytes.
package wecache_pkg;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 8;

    typedef enum logic [1:0] {
        KIND_LOAD      = 2'd0,
        KIND_GLOBAL_ST = 2'd1,
        KIND_LOCAL_ST  = 2'd2,
        KIND_WB_ST     = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_HIT    = 2'd0,
        ST_MISS   = 2'd1,
        ST_REFUSE = 2'd2,
        ST_IDLE   = 2'd3
    } rsp_status_e;

    typedef enum logic [1:0] {
        MQ_READ   = 2'd0,
        MQ_WRITE  = 2'd1,
        MQ_VICTIM = 2'd2
    } mq_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        kind;
        logic [SIZE_W-1:0] size;
    } mq_entry_t;
endpackage

// File: rtl/wecache_lru.sv
// Module: per-set LRU ages and victim choice.
// Every set keeps one age per way, and within a set the ages always form a
// permutation. Touching a way makes it age 0 and ages each way that was younger.
// The victim is the lowest free way if there is one, otherwise the oldest
// available way. Assumes NUM_WAYS >= 2.
module wecache_lru #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    localparam int IDX_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    look_set,
    input  logic [NUM_WAYS-1:0] free_ways,
    input  logic [NUM_WAYS-1:0] avail_ways,
    output logic [WAY_W-1:0]    vict_way,
    output logic                vict_found,
    input  logic                touch_en,
    input  logic [IDX_W-1:0]    touch_set,
    input  logic [WAY_W-1:0]    touch_way
);
    logic [WAY_W-1:0] age_q [NUM_SETS][NUM_WAYS];

    // Age update: reset to way index, and on a touch make the touched way youngest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int w = 0; w < NUM_WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    // Victim choice: the lowest free way first, otherwise the oldest available way.
    always_comb begin
        logic             got_free;
        logic             got_old;
        logic [WAY_W-1:0] best_age;
        got_free = 1'b0;
        got_old  = 1'b0;
        best_age = '0;
        vict_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (free_ways[w]) begin
                vict_way = WAY_W'(w);
                got_free = 1'b1;
            end
        end
        if (!got_free) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (avail_ways[w] && (!got_old || age_q[look_set][w] > best_age)) begin
                    vict_way = WAY_W'(w);
                    best_age = age_q[look_set][w];
                    got_old  = 1'b1;
                end
            end
        end
        vict_found = got_free | got_old;
    end
endmodule

// File: rtl/wecache_mq.sv
// Module: outbound miss queue that takes up to two pushes per cycle.
// Assumes DEPTH is a power of two, that push_b is raised only together with
// push_a, and that the caller never pushes more entries than are free.
module wecache_mq
    import wecache_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_a,
    input  mq_entry_t        ent_a,
    input  logic             push_b,
    input  mq_entry_t        ent_b,
    input  logic             pop,
    output mq_entry_t        head,
    output logic [CNT_W-1:0] count
);
    mq_entry_t        store_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    // Pointer and occupancy bookkeeping for pushes and pops in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_q + PTR_W'(push_a) + PTR_W'(push_b);
            rd_q  <= rd_q + PTR_W'(pop);
            cnt_q <= cnt_q + CNT_W'(push_a) + CNT_W'(push_b) - CNT_W'(pop);
        end
    end

    // Entry storage: the first push goes to the write pointer, the second one behind it.
    always_ff @(posedge clk) begin
        if (push_a) store_q[wr_q] <= ent_a;
        if (push_b) store_q[PTR_W'(wr_q + 1'b1)] <= ent_b;
    end

    assign head  = store_q[rd_q];
    assign count = cnt_q;
endmodule

// File: rtl/wecache_top.sv
// Module: write-evict set-associative data cache controller.
// Judges one request per cycle against the tag state, queues reads, write-throughs
// and victim writebacks, and completes pending ways from the fill port.
// Assumes LINE_BYTES fits in the size field and MQ_DEPTH >= 2.
module wecache_top
    import wecache_pkg::*;
#(
    parameter int NUM_SETS   = 4,
    parameter int NUM_WAYS   = 4,
    parameter int LINE_BYTES = 128,
    parameter int MQ_DEPTH   = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W     = $clog2(NUM_WAYS),
    localparam int WSEL_W    = $clog2(LINE_BYTES / 4),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int CNT_W     = $clog2(MQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [31:0]       req_wdata,
    output logic [1:0]        rsp_status,
    output logic              rsp_read_sent,
    output logic              rsp_write_sent,
    output logic              rsp_data_valid,
    output logic [31:0]       rsp_data,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_data,
    output logic              rdy_valid,
    output logic [ADDR_W-1:0] rdy_addr,
    output logic              mq_valid,
    input  logic              mq_ready,
    output logic [ADDR_W-1:0] mq_addr,
    output logic [1:0]        mq_kind,
    output logic [SIZE_W-1:0] mq_size
);
    logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0] vld_q   [NUM_SETS];
    logic [NUM_WAYS-1:0] pend_q  [NUM_SETS];
    logic [NUM_WAYS-1:0] dirty_q [NUM_SETS];
    logic [LINE_W-1:0]   line_q  [NUM_SETS][NUM_WAYS];

    logic [TAG_W-1:0]  r_tag, f_tag;
    logic [IDX_W-1:0]  r_idx, f_idx;
    logic [WSEL_W-1:0] r_wsel;
    assign r_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign r_idx  = req_addr[OFF_W +: IDX_W];
    assign r_wsel = req_addr[2 +: WSEL_W];
    assign f_tag  = fill_addr[ADDR_W-1 -: TAG_W];
    assign f_idx  = fill_addr[OFF_W +: IDX_W];

    logic             hit_any, pend_any, fill_hit;
    logic [WAY_W-1:0] hit_way, fill_way;

    // Tag compare for the request and the fill; pending ways never count as hits.
    always_comb begin
        hit_any  = 1'b0;
        pend_any = 1'b0;
        fill_hit = 1'b0;
        hit_way  = '0;
        fill_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (tag_q[r_idx][w] == r_tag && vld_q[r_idx][w]) begin
                hit_any = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (tag_q[r_idx][w] == r_tag && pend_q[r_idx][w]) pend_any = 1'b1;
            if (fill_valid && tag_q[f_idx][w] == f_tag && pend_q[f_idx][w]) begin
                fill_hit = 1'b1;
                fill_way = WAY_W'(w);
            end
        end
    end

    logic [WAY_W-1:0] vict_way;
    logic             vict_found;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;

    wecache_lru #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_set   (r_idx),
        .free_ways  (~vld_q[r_idx] & ~pend_q[r_idx]),
        .avail_ways (~pend_q[r_idx]),
        .vict_way   (vict_way),
        .vict_found (vict_found),
        .touch_en   (touch_en),
        .touch_set  (r_idx),
        .touch_way  (touch_way)
    );

    logic [CNT_W-1:0] mq_count;
    logic             push_a, push_b, mq_pop;
    mq_entry_t        ent_a, ent_b, mq_head;

    wecache_mq #(.DEPTH(MQ_DEPTH)) u_mq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_a (push_a),
        .ent_a  (ent_a),
        .push_b (push_b),
        .ent_b  (ent_b),
        .pop    (mq_pop),
        .head   (mq_head),
        .count  (mq_count)
    );

    assign mq_valid = (mq_count != '0);
    assign mq_pop   = mq_valid & mq_ready;
    assign mq_addr  = mq_head.addr;
    assign mq_kind  = mq_head.kind;
    assign mq_size  = mq_head.size;

    logic is_store, q_full, q_tight;
    assign is_store = (req_kind != KIND_LOAD);
    assign q_full   = (int'(mq_count) >= MQ_DEPTH);
    assign q_tight  = (int'(mq_count) + 1 >= MQ_DEPTH);

    rsp_status_e status;
    logic        do_inval, do_dirty, do_alloc, load_hit, glob_dirty_hit;

    // Request decision: result code, events, queue pushes and state actions.
    always_comb begin
        status    = ST_IDLE;
        rsp_read_sent  = 1'b0;
        rsp_write_sent = 1'b0;
        push_a    = 1'b0;
        push_b    = 1'b0;
        ent_a     = '{addr: req_addr, kind: MQ_WRITE, size: req_size};
        ent_b     = '{addr: {tag_q[r_idx][vict_way], r_idx, {OFF_W{1'b0}}},
                      kind: MQ_VICTIM, size: SIZE_W'(LINE_BYTES)};
        touch_en  = 1'b0;
        touch_way = hit_way;
        do_inval  = 1'b0;
        do_dirty  = 1'b0;
        do_alloc  = 1'b0;
        load_hit  = 1'b0;
        if (req_valid) begin
            if (pend_any) begin
                status = ST_REFUSE;
            end else if (is_store) begin
                if (hit_any && req_kind == KIND_GLOBAL_ST) begin
                    if (q_full) status = ST_REFUSE;
                    else begin
                        status         = ST_HIT;
                        rsp_write_sent = 1'b1;
                        push_a         = 1'b1;
                        do_inval       = 1'b1;
                    end
                end else if (hit_any) begin
                    status   = ST_HIT;
                    do_dirty = 1'b1;
                    touch_en = 1'b1;
                end else if (q_full) begin
                    status = ST_REFUSE;
                end else begin
                    status         = ST_MISS;
                    rsp_write_sent = 1'b1;
                    push_a         = 1'b1;
                end
            end else if (hit_any) begin
                status   = ST_HIT;
                load_hit = 1'b1;
                touch_en = 1'b1;
            end else if (!vict_found || q_tight) begin
                status = ST_REFUSE;
            end else begin
                status        = ST_MISS;
                rsp_read_sent = 1'b1;
                push_a        = 1'b1;
                ent_a         = '{addr: {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}},
                                  kind: MQ_READ, size: SIZE_W'(LINE_BYTES)};
                push_b        = vld_q[r_idx][vict_way] & dirty_q[r_idx][vict_way];
                do_alloc      = 1'b1;
                touch_en      = 1'b1;
                touch_way     = vict_way;
            end
        end
    end

    assign rsp_status     = status;
    assign glob_dirty_hit = req_valid && !pend_any && hit_any &&
                            req_kind == KIND_GLOBAL_ST && dirty_q[r_idx][hit_way];

    // Line state: invalidate, dirty, allocate pending, and complete on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                vld_q[s]   <= '0;
                pend_q[s]  <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < NUM_WAYS; w++) tag_q[s][w] <= '0;
            end
        end else begin
            if (do_inval) vld_q[r_idx][hit_way]   <= 1'b0;
            if (do_dirty) dirty_q[r_idx][hit_way] <= 1'b1;
            if (do_alloc) begin
                tag_q[r_idx][vict_way]   <= r_tag;
                vld_q[r_idx][vict_way]   <= 1'b0;
                pend_q[r_idx][vict_way]  <= 1'b1;
                dirty_q[r_idx][vict_way] <= 1'b0;
            end
            if (fill_hit) begin
                vld_q[f_idx][fill_way]   <= 1'b1;
                pend_q[f_idx][fill_way]  <= 1'b0;
                dirty_q[f_idx][fill_way] <= 1'b0;
            end
        end
    end

    // Line data: one word written by a store hit, a whole line by a fill.
    always_ff @(posedge clk) begin
        if (do_dirty) line_q[r_idx][hit_way][{r_wsel, 5'b0} +: 32] <= req_wdata;
        if (fill_hit) line_q[f_idx][fill_way] <= fill_data;
    end

    // Registered responses: load-hit data and fill completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data_valid <= 1'b0;
            rsp_data       <= '0;
            rdy_valid      <= 1'b0;
            rdy_addr       <= '0;
        end else begin
            rsp_data_valid <= load_hit;
            rsp_data       <= line_q[r_idx][hit_way][{r_wsel, 5'b0} +: 32];
            rdy_valid      <= fill_hit;
            rdy_addr       <= fill_addr;
        end
    end
endmodule

// File: rtl/wecache_chk.sv
// Module: assertion checker bound to wecache_top.
// Observes the ports together with the queue occupancy and the illegal-hit
// indication that the top drives.
module wecache_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic [1:0]       rsp_status,
    input logic             rsp_read_sent,
    input logic             rsp_write_sent,
    input logic             rsp_data_valid,
    input logic             fill_valid,
    input logic             rdy_valid,
    input logic             mq_valid,
    input logic             mq_ready,
    input logic [CNT_W-1:0] occ,
    input logic             glob_dirty_hit
);
    AST_IDLE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> rsp_status == 2'd3); // R1
    AST_DATA_AFTER_LOAD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data_valid |-> $past(req_valid && req_kind == 2'd0 && rsp_status == 2'd0)); // R1
    AST_READ_ONLY_ON_LOAD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_read_sent |-> (req_kind == 2'd0 && rsp_status == 2'd1)); // R2
    AST_WRITE_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_write_sent |-> (req_kind != 2'd0 && rsp_status != 2'd2)); // R5
    AST_REFUSE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status == 2'd2 |-> (!rsp_read_sent && !rsp_write_sent)); // R8
    AST_REFUSE_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status == 2'd2 && !(mq_valid && mq_ready)) |=> occ == $past(occ)); // R8
    AST_READY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |-> $past(fill_valid)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH); // R10
    AST_NO_GLOBAL_DIRTY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_dirty_hit); // R11
endmodule

bind wecache_top wecache_chk #(.DEPTH(MQ_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .rsp_status     (rsp_status),
    .rsp_read_sent  (rsp_read_sent),
    .rsp_write_sent (rsp_write_sent),
    .rsp_data_valid (rsp_data_valid),
    .fill_valid     (fill_valid),
    .rdy_valid      (rdy_valid),
    .mq_valid       (mq_valid),
    .mq_ready       (mq_ready),
    .occ            (mq_count),
    .glob_dirty_hit (glob_dirty_hit)
);

// File: tb/test_wecache_top.sv
// Bench: directed corner cases followed by seeded random traffic, all judged
// against a reference model of the requirements.
module test_wecache_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int LINE  = 128;
    localparam int DEPTH = 4;
    localparam int WORDS = LINE / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [31:0] req_addr = '0;
    logic [7:0] req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0] rsp_status;
    logic rsp_read_sent, rsp_write_sent, rsp_data_valid;
    logic [31:0] rsp_data;
    logic fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [LINE*8-1:0] fill_data = '0;
    logic rdy_valid;
    logic [31:0] rdy_addr;
    logic mq_valid;
    logic mq_ready = 1'b0;
    logic [31:0] mq_addr;
    logic [1:0] mq_kind;
    logic [7:0] mq_size;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wecache_top i_wecache_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_status(rsp_status), .rsp_read_sent(rsp_read_sent),
        .rsp_write_sent(rsp_write_sent), .rsp_data_valid(rsp_data_valid),
        .rsp_data(rsp_data), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_data(fill_data), .rdy_valid(rdy_valid), .rdy_addr(rdy_addr),
        .mq_valid(mq_valid), .mq_ready(mq_ready), .mq_addr(mq_addr),
        .mq_kind(mq_kind), .mq_size(mq_size)
    );

    int n_cmp = 0;
    int n_bad = 0;

    int          m_tag   [SETS][WAYS];
    bit          m_vld   [SETS][WAYS];
    bit          m_pend  [SETS][WAYS];
    bit          m_dirty [SETS][WAYS];
    int          m_age   [SETS][WAYS];
    logic [31:0] m_line  [SETS][WAYS][WORDS];
    logic [41:0] mq_m [$];

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // LRU rule of R3: the touched way becomes youngest, younger ways age by one.
    task automatic touch(int s, int w);
        int old = m_age[s][w];
        for (int v = 0; v < WAYS; v++)
            if (m_age[s][v] < old) m_age[s][v]++;
        m_age[s][w] = 0;
    endtask

    function automatic bit global_hits_dirty(logic [31:0] a);
        int tg = int'(a >> 9);
        int ix = int'((a >> 7) & 3);
        for (int w = 0; w < WAYS; w++)
            if (m_vld[ix][w] && m_tag[ix][w] == tg && m_dirty[ix][w]) return 1'b1;
        return 1'b0;
    endfunction

    // One cycle: drive at the falling edge, judge the combinational answer, update
    // the model, and check the registered outputs at the next falling edge.
    task automatic cyc(bit rv, logic [1:0] k, logic [31:0] a, logic [7:0] sz,
                       logic [31:0] wd, bit fv, logic [31:0] fa,
                       logic [LINE*8-1:0] fd, bit mr);
        int tg = int'(a >> 9);
        int ix = int'((a >> 7) & 3);
        int wi = int'((a >> 2) & 31);
        int ftg = int'(fa >> 9);
        int fix = int'((fa >> 7) & 3);
        int hw = -1, pw = -1, fw = -1, vw = -1, best = -1;
        int cnt = mq_m.size();
        logic [1:0] es = 2'd3;
        bit erd = 0, ewr = 0, lhit = 0, hpa = 0, hpb = 0;
        logic [31:0] ldata = '0;
        logic [41:0] pa = '0, pb = '0;
        string rt = "R1";
        req_valid = rv; req_kind = k; req_addr = a; req_size = sz; req_wdata = wd;
        fill_valid = fv; fill_addr = fa; fill_data = fd; mq_ready = mr;
        #2;
        for (int w = 0; w < WAYS; w++) begin
            if (m_tag[ix][w] == tg && m_vld[ix][w]) hw = w;
            if (m_tag[ix][w] == tg && m_pend[ix][w]) pw = w;
            if (fv && m_tag[fix][w] == ftg && m_pend[fix][w]) fw = w;
        end
        if (rv) begin
            if (pw >= 0) begin
                es = 2; rt = "R7";
            end else if (k != 0) begin
                if (hw >= 0 && k == 1) begin
                    if (cnt >= DEPTH) begin es = 2; rt = "R7"; end
                    else begin
                        es = 0; ewr = 1; rt = "R4"; hpa = 1; pa = {a, 2'd1, sz};
                        m_vld[ix][hw] = 0;
                    end
                end else if (hw >= 0) begin
                    es = 0; rt = "R6";
                    m_dirty[ix][hw] = 1; m_line[ix][hw][wi] = wd; touch(ix, hw);
                end else if (cnt >= DEPTH) begin
                    es = 2; rt = "R7";
                end else begin
                    es = 1; ewr = 1; rt = "R5"; hpa = 1; pa = {a, 2'd1, sz};
                end
            end else if (hw >= 0) begin
                es = 0; lhit = 1; ldata = m_line[ix][hw][wi]; touch(ix, hw);
            end else begin
                for (int w = 0; w < WAYS; w++)
                    if (vw < 0 && !m_vld[ix][w] && !m_pend[ix][w]) vw = w;
                if (vw < 0)
                    for (int w = 0; w < WAYS; w++)
                        if (!m_pend[ix][w] && m_age[ix][w] > best) begin
                            vw = w; best = m_age[ix][w];
                        end
                if (vw < 0 || cnt + 1 >= DEPTH) begin
                    es = 2; rt = "R7";
                end else begin
                    es = 1; erd = 1; rt = "R2"; hpa = 1;
                    pa = {a & ~32'd127, 2'd0, 8'd128};
                    if (m_vld[ix][vw] && m_dirty[ix][vw]) begin
                        hpb = 1; rt = "R3";
                        pb = {32'((m_tag[ix][vw] << 9) | (ix << 7)), 2'd2, 8'd128};
                    end
                    m_tag[ix][vw] = tg; m_vld[ix][vw] = 0;
                    m_pend[ix][vw] = 1; m_dirty[ix][vw] = 0; touch(ix, vw);
                end
            end
        end
        chk(rt, 64'(rsp_status), 64'(es));
        chk(es == 2 ? "R8" : rt, 64'(rsp_read_sent), 64'(erd));
        chk(es == 2 ? "R8" : rt, 64'(rsp_write_sent), 64'(ewr));
        chk("R10", 64'(mq_valid), 64'(cnt != 0));
        if (cnt != 0) chk("R10", 64'({mq_addr, mq_kind, mq_size}), 64'(mq_m[0]));
        if (mr && cnt != 0) void'(mq_m.pop_front());
        if (hpa) mq_m.push_back(pa);
        if (hpb) mq_m.push_back(pb);
        if (fw >= 0) begin
            m_vld[fix][fw] = 1; m_pend[fix][fw] = 0; m_dirty[fix][fw] = 0;
            for (int i = 0; i < WORDS; i++) m_line[fix][fw][i] = fd[i*32 +: 32];
        end
        @(posedge clk);
        @(negedge clk);
        chk("R1", 64'(rsp_data_valid), 64'(lhit));
        if (lhit) chk("R1", 64'(rsp_data), 64'(ldata));
        chk("R9", 64'(rdy_valid), 64'(fw >= 0));
        if (fw >= 0) chk("R9", 64'(rdy_addr), 64'(fa));
    endtask

    function automatic logic [LINE*8-1:0] rand_line();
        logic [LINE*8-1:0] l;
        for (int i = 0; i < WORDS; i++) l[i*32 +: 32] = $urandom;
        return l;
    endfunction

    function automatic logic [31:0] mk(int tg, int s, int w);
        return 32'((tg << 9) | (s << 7) | (w << 2));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] sd;
        sd = $urandom(32'h5eed);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_vld[s][w] = 0; m_pend[s][w] = 0;
                m_dirty[s][w] = 0; m_age[s][w] = w;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state seen at the ports
        chk("R12", 64'(mq_valid), 64'd0);
        chk("R12", 64'(rsp_status), 64'd3);
        chk("R12", 64'(rdy_valid), 64'd0);
        chk("R12", 64'(rsp_data_valid), 64'd0);

        // Directed corners, queue held back.
        cyc(1, 0, mk(1, 0, 3), 4, 0, 0, 0, '0, 0);              // R2 miss to A
        cyc(1, 0, mk(1, 0, 5), 4, 0, 0, 0, '0, 0);              // R7 pending A refused
        cyc(1, 0, mk(2, 0, 1), 4, 0, 1, mk(1, 0, 0), rand_line(), 0); // fill A with miss B
        cyc(1, 0, mk(1, 0, 3), 4, 0, 0, 0, '0, 0);              // R1 hit A with data
        cyc(1, 2, mk(1, 0, 7), 4, 32'hcafe_0007, 0, 0, '0, 0);  // R6 local store hit
        cyc(1, 0, mk(1, 0, 7), 4, 0, 0, mk(6, 3, 0), '0, 0);    // R6 read back
        cyc(0, 0, 0, 0, 0, 1, mk(6, 3, 0), rand_line(), 0);     // R9 unmatched fill ignored
        cyc(0, 0, 0, 0, 0, 1, mk(2, 0, 9), rand_line(), 0);     // R9 fill B
        cyc(1, 1, mk(2, 0, 2), 8, 32'h1, 0, 0, '0, 0);          // R4 global hit
        cyc(1, 0, mk(2, 0, 2), 4, 0, 0, 0, '0, 0);              // R7 count 3, load refused
        cyc(1, 1, mk(3, 1, 0), 12, 32'h2, 0, 0, '0, 0);         // R5 store miss, count 4
        cyc(1, 3, mk(3, 2, 0), 12, 32'h3, 0, 0, '0, 0);         // R7 full, store refused
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, 0, '0, 1); // R10 drain

        // Seeded random traffic.
        for (int n = 0; n < 4000; n++) begin
            bit rv = ($urandom % 100) < 85;
            logic [1:0] k = 2'($urandom % 4);
            logic [31:0] a = mk(1 + int'($urandom % 6), int'($urandom % 4), int'($urandom % 32));
            logic [7:0] sz = (k == 0) ? 8'd4 : 8'(1 + $urandom % 16);
            bit fv = 0;
            logic [31:0] fa = '0;
            if ((k == 2'd0) && ($urandom % 3 == 0)) k = 2'd0;
            if (k == 2'd1 && global_hits_dirty(a)) k = 2'd2;
            if ($urandom % 3 == 0) begin
                int s = int'($urandom % 4);
                fv = 1;
                fa = $urandom & 32'h0000_0fff;
                for (int w = 0; w < WAYS; w++)
                    if (m_pend[s][w]) fa = 32'((m_tag[s][w] << 9) | (s << 7) | ($urandom % 128));
            end
            cyc(rv, k, a, sz, $urandom, fv, fa, rand_line(), ($urandom % 2) == 0);
        end
        finish_run();
    end
endmodule